// File: doc/BRIEF.md
# Multiplexed Channel Context Controller

This block runs one transfer control unit on behalf of many devices. For every device it keeps a small saved context: a transfer state, a memory address and an order flag. Each context lives in its own slot of a register-based store. When one or more devices ask for service, a service latch captures the lowest-numbered requester. It then loads that device's slot into working registers and presents the transfer phase that the saved state calls for. While the latch is set, an incoming data poll is held back and does not travel further down the chain.

Each device context steps through three phases. First comes a table fetch: the unit puts a table address equal to four times the device number on the bus, and the returned word becomes the device's program address. Next comes a control-word fetch, which is a read at the program address. The top bit of the returned control word sets the order flag. Last comes an address-word transfer, which is a read or a write depending on that flag. After the address-word transfer the device goes back to fetching control words.

The end of each phase is marked by a completion signal. On its rising edge the updated context is written back to the device's slot. On its falling edge the service latch is released. If the device is still requesting, the latch arms again on the following clock, so transfers from several devices interleave.

Top module: `chan_ctx_ctrl`

## Requirements
- R1: After reset, `busy` and `xfer_valid` are 0, `xfer_cmd` is 0 and `poll_out` follows `poll_in`. Every device context starts in the table-fetch state with address 0 and order 0.
- R2: When `busy` is 0 and any bit of `dev_req` is 1, `busy` becomes 1 on the next clock edge. While `busy` is 1, `poll_out` is 0. When `dev_req` is all zero, `busy` stays 0.
- R3: When the latch sets, `dev_id` takes the lowest index whose `dev_req` bit is 1. `dev_id` holds that value for as long as `busy` stays 1.
- R4: In the table-fetch state, `xfer_valid` is 1, `xfer_cmd` is 3 (table fetch) and `xfer_addr` equals `dev_id` times 4.
- R5: A completion in the table-fetch state does three things to the device's context. The address becomes `data_in`. The state becomes control-word fetch. The order is left unchanged.
- R6: In the control-word-fetch state, `xfer_cmd` is 1 (read from memory) and `xfer_addr` is the device's saved address.
- R7: A completion in the control-word-fetch state sets the device's order to `data_in[DW-1]`. It also stores the address plus one, wrapping modulo 2^DW, and moves the state to address-word transfer.
- R8: In the address-word-transfer state, `xfer_cmd` is 1 when the order is 0 and 2 (write to memory) when the order is 1, and `xfer_addr` is the saved address. A completion in this state stores the address plus one, keeps the order and moves the state back to control-word fetch.
- R9: The latch clears on the clock edge that follows the falling edge of `done_in`. If the request is still held, the latch sets again on the next clock edge.
- R10: After the rising edge of `done_in` has been taken, `xfer_valid` is 0 until the latch clears. Each service therefore produces exactly one write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | NDEV | Service request, one bit per device |
| poll_in | input | 1 | Incoming data poll |
| poll_out | output | 1 | Poll passed on when the unit is idle |
| done_in | input | 1 | Completion signal for the current phase |
| data_in | input | DW | Word returned at completion |
| busy | output | 1 | Service latch state |
| dev_id | output | $clog2(NDEV) | Device being served |
| xfer_valid | output | 1 | First-phase response active |
| xfer_cmd | output | 2 | 0 none, 1 read, 2 write, 3 table fetch |
| xfer_addr | output | DW | Address placed on the bus |

## Verification
The hardest case to reach is a single device advancing through all three phases while other devices' contexts sit half-finished in the store. This exposes any write-back to the wrong slot, and any order flag that leaks from one device to another. The stimulus reaches it with random request masks, which make the lowest-index winner change from service to service, and with held requests that re-arm the latch straight after a release. A directed table word of all ones drives the address increment through its wrap to zero.

// File: rtl/chan_pkg.sv
package chan_pkg;

    typedef enum logic [1:0] {
        ST_TABLE = 2'd0,
        ST_CTRL  = 2'd1,
        ST_AWORD = 2'd2
    } chan_state_e;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_TABLE = 2'd3
    } chan_cmd_e;

    function automatic chan_cmd_e aword_cmd(input logic order);
        return order ? CMD_WRITE : CMD_READ;
    endfunction

endpackage

// File: rtl/chan_svc_latch.sv
module chan_svc_latch #(
    parameter int NDEV = 8,
    localparam int IW = $clog2(NDEV)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NDEV-1:0] dev_req,
    input  logic            done_in,
    input  logic            poll_in,
    output logic            poll_out,
    output logic            busy,
    output logic            load,
    output logic            done_rise,
    output logic [IW-1:0]   pick,
    output logic [IW-1:0]   dev_sel
);
    logic done_q;
    logic found;
    logic release_now;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < NDEV; i++) begin
            if (dev_req[i] && !found) begin
                pick  = IW'(i);
                found = 1'b1;
            end
        end
    end

    assign load        = !busy && found;
    assign release_now = busy && done_q && !done_in;
    assign done_rise   = busy && done_in && !done_q;
    assign poll_out    = poll_in && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done_q  <= 1'b0;
            dev_sel <= '0;
        end else begin
            done_q <= done_in;
            if (release_now) begin
                busy <= 1'b0;
            end else if (load) begin
                busy    <= 1'b1;
                dev_sel <= pick;
            end
        end
    end
endmodule

// File: rtl/chan_ctx_store.sv
module chan_ctx_store
    import chan_pkg::*;
#(
    parameter int NDEV = 8,
    parameter int DW   = 16,
    localparam int IW  = $clog2(NDEV)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [IW-1:0] widx,
    input  chan_state_e wstate,
    input  logic [DW-1:0] waddr,
    input  logic        worder,
    input  logic [IW-1:0] ridx,
    output chan_state_e rstate,
    output logic [DW-1:0] raddr,
    output logic        rorder
);
    chan_state_e   st_mem [NDEV];
    logic [DW-1:0] ad_mem [NDEV];
    logic          od_mem [NDEV];

    for (genvar g = 0; g < NDEV; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                st_mem[g] <= ST_TABLE;
                ad_mem[g] <= '0;
                od_mem[g] <= 1'b0;
            end else if (we && widx == IW'(g)) begin
                st_mem[g] <= wstate;
                ad_mem[g] <= waddr;
                od_mem[g] <= worder;
            end
        end
    end

    assign rstate = st_mem[ridx];
    assign raddr  = ad_mem[ridx];
    assign rorder = od_mem[ridx];
endmodule

// File: rtl/chan_xfer_unit.sv
module chan_xfer_unit
    import chan_pkg::*;
#(
    parameter int NDEV = 8,
    parameter int DW   = 16,
    localparam int IW  = $clog2(NDEV)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy,
    input  logic          load,
    input  logic          done_rise,
    input  logic [IW-1:0] dev_sel,
    input  chan_state_e   ld_state,
    input  logic [DW-1:0] ld_addr,
    input  logic          ld_order,
    input  logic [DW-1:0] data_in,
    output logic          wb_en,
    output chan_state_e   wb_state,
    output logic [DW-1:0] wb_addr,
    output logic          wb_order,
    output logic          xfer_valid,
    output chan_cmd_e     xfer_cmd,
    output logic [DW-1:0] xfer_addr
);
    chan_state_e   state_r;
    logic [DW-1:0] addr_r;
    logic          order_r;
    logic          served;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_r <= ST_TABLE;
            addr_r  <= '0;
            order_r <= 1'b0;
            served  <= 1'b0;
        end else if (load) begin
            state_r <= ld_state;
            addr_r  <= ld_addr;
            order_r <= ld_order;
            served  <= 1'b0;
        end else if (done_rise) begin
            served  <= 1'b1;
        end
    end

    assign xfer_valid = busy && !served;
    assign wb_en      = done_rise;

    always_comb begin
        xfer_cmd  = CMD_NONE;
        xfer_addr = '0;
        if (xfer_valid) begin
            unique case (state_r)
                ST_CTRL: begin
                    xfer_cmd  = CMD_READ;
                    xfer_addr = addr_r;
                end
                ST_AWORD: begin
                    xfer_cmd  = aword_cmd(order_r);
                    xfer_addr = addr_r;
                end
                default: begin
                    xfer_cmd  = CMD_TABLE;
                    xfer_addr = DW'(dev_sel) << 2;
                end
            endcase
        end
    end

    always_comb begin
        wb_order = order_r;
        unique case (state_r)
            ST_CTRL: begin
                wb_state = ST_AWORD;
                wb_addr  = addr_r + 1'b1;
                wb_order = data_in[DW-1];
            end
            ST_AWORD: begin
                wb_state = ST_CTRL;
                wb_addr  = addr_r + 1'b1;
            end
            default: begin
                wb_state = ST_CTRL;
                wb_addr  = data_in;
            end
        endcase
    end
endmodule

// File: rtl/chan_ctx_ctrl.sv
module chan_ctx_ctrl
    import chan_pkg::*;
#(
    parameter int NDEV = 8,
    parameter int DW   = 16,
    localparam int IW  = $clog2(NDEV)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NDEV-1:0] dev_req,
    input  logic            poll_in,
    output logic            poll_out,
    input  logic            done_in,
    input  logic [DW-1:0]   data_in,
    output logic            busy,
    output logic [IW-1:0]   dev_id,
    output logic            xfer_valid,
    output logic [1:0]      xfer_cmd,
    output logic [DW-1:0]   xfer_addr
);
    logic          load, done_rise;
    logic [IW-1:0] pick;
    chan_state_e   rd_state, wb_state;
    logic [DW-1:0] rd_addr, wb_addr;
    logic          rd_order, wb_order, wb_en;
    chan_cmd_e     cmd_e;

    chan_svc_latch #(.NDEV(NDEV)) u_latch (
        .clk(clk), .rst(rst), .dev_req(dev_req), .done_in(done_in),
        .poll_in(poll_in), .poll_out(poll_out), .busy(busy),
        .load(load), .done_rise(done_rise), .pick(pick), .dev_sel(dev_id)
    );

    chan_ctx_store #(.NDEV(NDEV), .DW(DW)) u_store (
        .clk(clk), .rst(rst), .we(wb_en), .widx(dev_id),
        .wstate(wb_state), .waddr(wb_addr), .worder(wb_order),
        .ridx(pick), .rstate(rd_state), .raddr(rd_addr), .rorder(rd_order)
    );

    chan_xfer_unit #(.NDEV(NDEV), .DW(DW)) u_xfer (
        .clk(clk), .rst(rst), .busy(busy), .load(load), .done_rise(done_rise),
        .dev_sel(dev_id), .ld_state(rd_state), .ld_addr(rd_addr),
        .ld_order(rd_order), .data_in(data_in), .wb_en(wb_en),
        .wb_state(wb_state), .wb_addr(wb_addr), .wb_order(wb_order),
        .xfer_valid(xfer_valid), .xfer_cmd(cmd_e), .xfer_addr(xfer_addr)
    );

    assign xfer_cmd = cmd_e;
endmodule

// File: rtl/chan_ctx_checker.sv
module chan_ctx_checker #(
    parameter int NDEV = 8,
    parameter int DW   = 16,
    localparam int IW  = $clog2(NDEV)
) (
    input logic            clk,
    input logic            rst,
    input logic [NDEV-1:0] dev_req,
    input logic            poll_out,
    input logic            done_in,
    input logic            busy,
    input logic [IW-1:0]   dev_id,
    input logic            xfer_valid,
    input logic [1:0]      xfer_cmd
);
    assert_poll_block_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> !poll_out);

    assert_latch_set_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && dev_req != '0) |=> busy);

    assert_id_hold_R3: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(dev_id)));

    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(done_in) && !done_in) |=> !busy);

    assert_valid_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> busy);

    assert_one_shot_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $rose(done_in)) |=> !xfer_valid);

    assert_cmd_present_R4: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (xfer_cmd != 2'd0));
endmodule

bind chan_ctx_ctrl chan_ctx_checker #(.NDEV(NDEV), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .dev_req(dev_req), .poll_out(poll_out),
    .done_in(done_in), .busy(busy), .dev_id(dev_id),
    .xfer_valid(xfer_valid), .xfer_cmd(xfer_cmd)
);

// File: tb/test_chan_ctx_ctrl.sv
module test_chan_ctx_ctrl;
    localparam int NDEV = 8;
    localparam int DW   = 16;
    localparam int IW   = $clog2(NDEV);

    logic            clk = 1'b0;
    logic            rst;
    logic [NDEV-1:0] dev_req;
    logic            poll_in, poll_out, done_in, busy, xfer_valid;
    logic [DW-1:0]   data_in, xfer_addr;
    logic [IW-1:0]   dev_id;
    logic [1:0]      xfer_cmd;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // model of saved contexts: state 0 table, 1 ctrl, 2 address word
    int          m_st [NDEV];
    logic [DW-1:0] m_ad [NDEV];
    logic        m_od [NDEV];

    always #10 clk = ~clk;

    chan_ctx_ctrl #(.NDEV(NDEV), .DW(DW)) i_chan_ctx_ctrl (
        .clk(clk), .rst(rst), .dev_req(dev_req), .poll_in(poll_in),
        .poll_out(poll_out), .done_in(done_in), .data_in(data_in),
        .busy(busy), .dev_id(dev_id), .xfer_valid(xfer_valid),
        .xfer_cmd(xfer_cmd), .xfer_addr(xfer_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int lowest(input logic [NDEV-1:0] m);
        for (int i = 0; i < NDEV; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic logic [1:0] exp_cmd(input int d);
        if (m_st[d] == 0) return 2'd3;
        if (m_st[d] == 1) return 2'd1;
        return m_od[d] ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [DW-1:0] exp_addr(input int d);
        if (m_st[d] == 0) return DW'(d) << 2;
        return m_ad[d];
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // one service: optionally change request mask, run one completion
    task automatic service(input logic [NDEV-1:0] mask, input logic [DW-1:0] word, input bit keep);
        int d;
        if (!keep) dev_req = mask;
        tick();
        d = lowest(dev_req);
        chk(busy == 1'b1, keep ? "R9 rearm" : "R2 set", busy, 1);
        chk(poll_out == 1'b0, "R2 poll blocked", poll_out, 0);
        chk(dev_id == IW'(d), "R3 lowest device", dev_id, d);
        chk(xfer_valid == 1'b1, "R4 valid", xfer_valid, 1);
        chk(xfer_cmd == exp_cmd(d),
            m_st[d] == 0 ? "R4 cmd" : (m_st[d] == 1 ? "R6 cmd" : "R8 cmd"),
            xfer_cmd, exp_cmd(d));
        chk(xfer_addr == exp_addr(d),
            m_st[d] == 0 ? "R4 addr" : (m_st[d] == 1 ? "R6 addr" : "R8 addr"),
            xfer_addr, exp_addr(d));
        done_in = 1'b1;
        data_in = word;
        tick();
        chk(xfer_valid == 1'b0, "R10 one shot", xfer_valid, 0);
        chk(busy == 1'b1, "R9 held while done high", busy, 1);
        case (m_st[d])
            0: begin m_ad[d] = word; m_st[d] = 1; end                      // R5
            1: begin m_od[d] = word[DW-1]; m_ad[d] = m_ad[d] + 1'b1; m_st[d] = 2; end // R7
            default: begin m_ad[d] = m_ad[d] + 1'b1; m_st[d] = 1; end      // R8
        endcase
        done_in = 1'b0;
        tick();
        chk(busy == 1'b0, "R9 release", busy, 0);
        chk(poll_out == poll_in, "R2 poll passes", poll_out, poll_in);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NDEV; i++) begin m_st[i] = 0; m_ad[i] = '0; m_od[i] = 1'b0; end
        rst = 1'b1; dev_req = '0; poll_in = 1'b1; done_in = 1'b0; data_in = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(xfer_valid == 1'b0, "R1 valid", xfer_valid, 0);
        chk(xfer_cmd == 2'd0, "R1 cmd", xfer_cmd, 0);
        chk(poll_out == 1'b1, "R1 poll", poll_out, 1);
        // R2 no request keeps idle
        tick(); tick();
        chk(busy == 1'b0, "R2 idle with no request", busy, 0);

        // directed: device 5 table fetch with all-ones word, wrap on R7
        service(8'b1010_0000, 16'hFFFF, 1'b0);   // R5
        service(8'b1010_0000, 16'h8000, 1'b1);   // R6/R7, address wraps to 0
        service(8'b1010_0000, 16'h1234, 1'b1);   // R8 write order
        chk(m_ad[5] == 16'h0001, "R7 wrap model", m_ad[5], 16'h0001);
        // another device takes over mid-program of device 5
        service(8'b1010_0100, 16'h0040, 1'b0);   // device 2 table
        service(8'b1010_0000, 16'h0000, 1'b0);   // device 5 ctrl, order 0
        service(8'b1010_0000, 16'h0000, 1'b1);   // device 5 address word, read

        // random
        for (int n = 0; n < 60; n++) begin
            logic [NDEV-1:0] m;
            logic [DW-1:0] w;
            m = NDEV'($urandom);
            if (m == '0) m = NDEV'(1) << ($urandom % NDEV);
            w = DW'($urandom);
            poll_in = 1'($urandom);
            service(m, w, ($urandom % 3) == 0 && n > 0);
        end

        dev_req = '0;
        tick(); tick();
        chk(busy == 1'b0, "R2 idle after requests drop", busy, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule